// File: doc/BRIEF.md
# Two-Level Mapped Interrupt Router

This block gathers a wide vector of system event lines and delivers them to a small set of host interrupt lines. Each event line is watched for a rising edge. An edge sets a pending flag, and the flag stays set until software clears it. Routing passes through two programmable many-to-one tables. The first table gives every event a channel number. The second table gives every channel a host number. An event takes part in routing only when its enable bit is set. A host line asserts only when three things are true: the global switch is on, that host is enabled, and at least one enabled pending event reaches it through both tables.

Software sees the block through a plain 32-bit synchronous bus, with one write strobe, one read strobe and word addresses. Read data is registered. For each host, a per-host index register reports the winning pending event, so a handler can find its source with a single read. Software then clears that event's pending bit. No acknowledge handshake exists beyond that clear.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, all of the following are zero: every map field, every event enable, every pending bit, every host enable and the global switch. `host_irq` is all-zero, and every per-host index register reads 0x80000000.
- R2: A 0-to-1 change on `evt_in[e]` between two clock edges sets pending bit e, whether or not event e is enabled. A line that stays high does not set the bit again after software clears it.
- R3: Writing the status word at 0x18+w clears pending bit 32w+b for each 1 in data bit b; 0 bits have no effect. A rising edge in the same cycle as a clear of the same bit leaves the bit set. Reading 0x18+w returns pending bits 32w..32w+31.
- R4: Writing 0x08+w sets enable bit 32w+b for each 1 in data bit b. Writing 0x10+w clears enable bit 32w+b for each 1 in data bit b. Reading either address returns the enable bits. Bits beyond the event count read 0.
- R5: Channel map word k sits at 0x40+k and covers events 4k..4k+3. Event e uses data bits [(e mod 4)*8 +: 4]. The upper four bits of each byte are not stored and read 0.
- R6: Host map word k sits at 0x70+k and covers channels 4k..4k+3, with the same byte packing. A host field of N_HOST or more routes that channel to no host.
- R7: Writing a host index h below N_HOST to 0x01 enables host h. Writing it to 0x02 disables host h. Index values of N_HOST or more change nothing. Reading 0x03 returns the host-enable mask in bits [N_HOST-1:0].
- R8: Bit 0 of 0x00 is the global switch. While it is 0, every `host_irq` bit is 0.
- R9: `host_irq[h]` is 1 exactly when all of these hold: the global switch is on, host h is enabled, and some event that is both enabled and pending has a channel whose host field equals h.
- R10: Reading 0x80+h returns the event number of the winning event among the enabled, pending events routed to host h. The lowest channel number wins, and within a channel the lowest event number wins. If no such event exists, the read returns 0x80000000. The result does not depend on host enables or the global switch.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_re`. Unassigned addresses read 0. Writes to read-only addresses (0x03, 0x80+h) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | N_EVT | System event lines |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| host_irq | output | N_HOST | Host interrupt lines |

## Verification
The bench builds the router with 40 events, 20 channels and 10 hosts. The second enable and status words are therefore only partly populated, which exercises the read-as-zero bits. Channels 16 to 19 cannot be reached by a 4-bit channel field. Random host fields of 10 to 15 land on the route-to-nowhere case, and random host-index writes of 10 to 15 land on the ignored-index case. Directed cases cover the priority ordering, the edge-versus-clear collision and the held-high line that must not re-latch. Thousands of random writes, reads and event pulses are then checked against a bench model of the tables.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
    localparam int ADDR_W = 8;
    localparam int FLD_W  = 4;
    localparam int SLOTS  = 4;
    localparam int SLOT_W = 8;
    localparam logic [31:0] IDX_NONE = 32'h8000_0000;

    localparam logic [7:0] A_GLB   = 8'h00;
    localparam logic [7:0] A_HSET  = 8'h01;
    localparam logic [7:0] A_HCLR  = 8'h02;
    localparam logic [7:0] A_HMSK  = 8'h03;
    localparam logic [7:0] B_ENSET = 8'h08;
    localparam logic [7:0] B_ENCLR = 8'h10;
    localparam logic [7:0] B_STAT  = 8'h18;
    localparam logic [7:0] B_CMAP  = 8'h40;
    localparam logic [7:0] B_HMAP  = 8'h70;
    localparam logic [7:0] B_PRIO  = 8'h80;

    typedef enum logic [3:0] {
        RG_NONE, RG_GLB, RG_HSET, RG_HCLR, RG_HMSK,
        RG_ENSET, RG_ENCLR, RG_STAT, RG_CMAP, RG_HMAP, RG_PRIO
    } reg_region_e;
endpackage

// File: rtl/irq_evt_bank.sv
`timescale 1ns/1ps
module irq_evt_bank #(
    parameter int N_EVT = 160
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_in,
    input  logic             en_set_we,
    input  logic             en_clr_we,
    input  logic             st_clr_we,
    input  logic [7:0]       word_sel,
    input  logic [31:0]      wdata,
    output logic [N_EVT-1:0] en_q,
    output logic [N_EVT-1:0] pend_q,
    output logic [N_EVT-1:0] prev_q
);
    localparam int N_EW = (N_EVT + 31) / 32;

    logic [N_EW*32-1:0] mask_full;
    logic [N_EVT-1:0]   wmask;
    logic [N_EVT-1:0]   rise;

    always_comb begin
        mask_full = '0;
        for (int w = 0; w < N_EW; w++) begin
            if (int'(word_sel) == w) mask_full[w*32 +: 32] = wdata;
        end
    end

    assign wmask = mask_full[N_EVT-1:0];
    assign rise  = evt_in & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= evt_in;
            if (en_set_we)      en_q <= en_q | wmask;
            else if (en_clr_we) en_q <= en_q & ~wmask;
            pend_q <= (pend_q & ~(st_clr_we ? wmask : '0)) | rise;
        end
    end
endmodule

// File: rtl/irq_map_tables.sv
`timescale 1ns/1ps
module irq_map_tables import irq_route_pkg::*; #(
    parameter int N_EVT = 160,
    parameter int N_CH  = 20
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmap_we,
    input  logic                   hmap_we,
    input  logic [7:0]             word_sel,
    input  logic [SLOTS*FLD_W-1:0] fld_in,
    output logic [N_EVT*FLD_W-1:0] evt_ch,
    output logic [N_CH*FLD_W-1:0]  ch_host
);
    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        logic [FLD_W-1:0] fld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fld_q <= '0;
            else if (cmap_we && int'(word_sel) == e / SLOTS)
                fld_q <= fld_in[(e % SLOTS)*FLD_W +: FLD_W];
        end
        assign evt_ch[e*FLD_W +: FLD_W] = fld_q;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [FLD_W-1:0] fld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fld_q <= '0;
            else if (hmap_we && int'(word_sel) == c / SLOTS)
                fld_q <= fld_in[(c % SLOTS)*FLD_W +: FLD_W];
        end
        assign ch_host[c*FLD_W +: FLD_W] = fld_q;
    end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick import irq_route_pkg::*; #(
    parameter int N_EVT  = 160,
    parameter int N_CH   = 20,
    parameter int N_HOST = 10,
    parameter int IW     = 8
)(
    input  logic [N_EVT-1:0]       elig,
    input  logic [N_EVT*FLD_W-1:0] evt_ch,
    input  logic [N_CH*FLD_W-1:0]  ch_host,
    output logic [N_HOST-1:0]      host_hit,
    output logic [N_HOST*IW-1:0]   host_idx
);
    logic [N_CH-1:0]    ch_hit;
    logic [N_CH*IW-1:0] ch_idx;

    // stage 1: lowest eligible event per channel
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic          hit_c;
        logic [IW-1:0] idx_c;
        always_comb begin
            hit_c = 1'b0;
            idx_c = '0;
            for (int e = N_EVT - 1; e >= 0; e--) begin
                if (elig[e] && int'(evt_ch[e*FLD_W +: FLD_W]) == c) begin
                    hit_c = 1'b1;
                    idx_c = IW'(e);
                end
            end
        end
        assign ch_hit[c]            = hit_c;
        assign ch_idx[c*IW +: IW]   = idx_c;
    end

    // stage 2: lowest active channel per host
    for (genvar h = 0; h < N_HOST; h++) begin : g_host
        logic          hit_h;
        logic [IW-1:0] idx_h;
        always_comb begin
            hit_h = 1'b0;
            idx_h = '0;
            for (int c = N_CH - 1; c >= 0; c--) begin
                if (ch_hit[c] && int'(ch_host[c*FLD_W +: FLD_W]) == h) begin
                    hit_h = 1'b1;
                    idx_h = ch_idx[c*IW +: IW];
                end
            end
        end
        assign host_hit[h]          = hit_h;
        assign host_idx[h*IW +: IW] = idx_h;
    end
endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl import irq_route_pkg::*; #(
    parameter int N_EVT  = 160,
    parameter int N_CH   = 20,
    parameter int N_HOST = 10
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_in,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_HOST-1:0] host_irq
);
    localparam int N_EW  = (N_EVT + 31) / 32;
    localparam int N_CMW = (N_EVT + SLOTS - 1) / SLOTS;
    localparam int N_HMW = (N_CH + SLOTS - 1) / SLOTS;
    localparam int IW    = (N_EVT > 1) ? $clog2(N_EVT) : 1;

    reg_region_e region;
    logic [7:0]  widx;

    logic                   glb_en_q;
    logic [N_HOST-1:0]      hen_q;
    logic [N_EVT-1:0]       en_q, pend_q, evt_prev_q;
    logic [N_EVT*FLD_W-1:0] evt_ch;
    logic [N_CH*FLD_W-1:0]  ch_host;
    logic [N_HOST-1:0]      prio_hit;
    logic [N_HOST*IW-1:0]   prio_idx;
    logic [SLOTS*FLD_W-1:0] fld_in;
    logic [31:0]            rd_mux;

    // address decode
    always_comb begin
        region = RG_NONE;
        widx   = '0;
        if (bus_addr == A_GLB)       region = RG_GLB;
        else if (bus_addr == A_HSET) region = RG_HSET;
        else if (bus_addr == A_HCLR) region = RG_HCLR;
        else if (bus_addr == A_HMSK) region = RG_HMSK;
        else if (bus_addr >= B_ENSET && bus_addr < B_ENSET + 8'(N_EW)) begin
            region = RG_ENSET; widx = bus_addr - B_ENSET;
        end else if (bus_addr >= B_ENCLR && bus_addr < B_ENCLR + 8'(N_EW)) begin
            region = RG_ENCLR; widx = bus_addr - B_ENCLR;
        end else if (bus_addr >= B_STAT && bus_addr < B_STAT + 8'(N_EW)) begin
            region = RG_STAT; widx = bus_addr - B_STAT;
        end else if (bus_addr >= B_CMAP && bus_addr < B_CMAP + 8'(N_CMW)) begin
            region = RG_CMAP; widx = bus_addr - B_CMAP;
        end else if (bus_addr >= B_HMAP && bus_addr < B_HMAP + 8'(N_HMW)) begin
            region = RG_HMAP; widx = bus_addr - B_HMAP;
        end else if (bus_addr >= B_PRIO && bus_addr < B_PRIO + 8'(N_HOST)) begin
            region = RG_PRIO; widx = bus_addr - B_PRIO;
        end
    end

    always_comb begin
        for (int s = 0; s < SLOTS; s++)
            fld_in[s*FLD_W +: FLD_W] = bus_wdata[s*SLOT_W +: FLD_W];
    end

    irq_evt_bank #(.N_EVT(N_EVT)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .en_set_we (bus_we && region == RG_ENSET),
        .en_clr_we (bus_we && region == RG_ENCLR),
        .st_clr_we (bus_we && region == RG_STAT),
        .word_sel  (widx),
        .wdata     (bus_wdata),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .prev_q    (evt_prev_q)
    );

    irq_map_tables #(.N_EVT(N_EVT), .N_CH(N_CH)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmap_we  (bus_we && region == RG_CMAP),
        .hmap_we  (bus_we && region == RG_HMAP),
        .word_sel (widx),
        .fld_in   (fld_in),
        .evt_ch   (evt_ch),
        .ch_host  (ch_host)
    );

    irq_prio_pick #(.N_EVT(N_EVT), .N_CH(N_CH), .N_HOST(N_HOST), .IW(IW)) u_pick (
        .elig     (pend_q & en_q),
        .evt_ch   (evt_ch),
        .ch_host  (ch_host),
        .host_hit (prio_hit),
        .host_idx (prio_idx)
    );

    // global switch and host enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_en_q <= 1'b0;
            hen_q    <= '0;
        end else if (bus_we) begin
            unique case (region)
                RG_GLB:  glb_en_q <= bus_wdata[0];
                RG_HSET: for (int h = 0; h < N_HOST; h++)
                             if (bus_wdata == 32'(h)) hen_q[h] <= 1'b1;
                RG_HCLR: for (int h = 0; h < N_HOST; h++)
                             if (bus_wdata == 32'(h)) hen_q[h] <= 1'b0;
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rd_mux = '0;
        unique case (region)
            RG_GLB:  rd_mux[0] = glb_en_q;
            RG_HMSK: rd_mux[N_HOST-1:0] = hen_q;
            RG_ENSET, RG_ENCLR:
                for (int b = 0; b < 32; b++)
                    if (int'(widx)*32 + b < N_EVT) rd_mux[b] = en_q[int'(widx)*32 + b];
            RG_STAT:
                for (int b = 0; b < 32; b++)
                    if (int'(widx)*32 + b < N_EVT) rd_mux[b] = pend_q[int'(widx)*32 + b];
            RG_CMAP:
                for (int s = 0; s < SLOTS; s++)
                    if (int'(widx)*SLOTS + s < N_EVT)
                        rd_mux[s*SLOT_W +: FLD_W] = evt_ch[(int'(widx)*SLOTS + s)*FLD_W +: FLD_W];
            RG_HMAP:
                for (int s = 0; s < SLOTS; s++)
                    if (int'(widx)*SLOTS + s < N_CH)
                        rd_mux[s*SLOT_W +: FLD_W] = ch_host[(int'(widx)*SLOTS + s)*FLD_W +: FLD_W];
            RG_PRIO:
                for (int h = 0; h < N_HOST; h++)
                    if (int'(widx) == h)
                        rd_mux = prio_hit[h] ? 32'(prio_idx[h*IW +: IW]) : IDX_NONE;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    assign host_irq = {N_HOST{glb_en_q}} & hen_q & prio_hit;
endmodule

// File: rtl/irq_route_chk.sv
`timescale 1ns/1ps
module irq_route_chk import irq_route_pkg::*; #(
    parameter int N_EVT  = 160,
    parameter int N_HOST = 10
)(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [N_EVT-1:0]  evt_in,
    input logic [N_HOST-1:0] host_irq,
    input logic              glb_en_q,
    input logic [N_HOST-1:0] hen_q,
    input logic [N_EVT-1:0]  pend_q,
    input logic [N_EVT-1:0]  evt_prev_q
);
    localparam int W0 = (N_EVT < 32) ? N_EVT : 32;

    // R8
    glb_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_q |-> host_irq == '0);

    // R2
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_in & ~evt_prev_q)) |=>
        ((pend_q & $past(evt_in & ~evt_prev_q)) == $past(evt_in & ~evt_prev_q)));

    // R7
    host_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_HSET && bus_wdata < N_HOST) |=>
        (|(hen_q & (N_HOST'(1) << $past(bus_wdata[4:0])))));

    // R7
    host_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_HCLR && bus_wdata < N_HOST) |=>
        !(|(host_irq & (N_HOST'(1) << $past(bus_wdata[4:0])))));

    // R3
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == B_STAT) |=>
        ((pend_q[W0-1:0] & $past(bus_wdata[W0-1:0] & ~(evt_in[W0-1:0] & ~evt_prev_q[W0-1:0]))) == '0));
endmodule

bind irq_route_ctrl irq_route_chk #(.N_EVT(N_EVT), .N_HOST(N_HOST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .evt_in     (evt_in),
    .host_irq   (host_irq),
    .glb_en_q   (glb_en_q),
    .hen_q      (hen_q),
    .pend_q     (pend_q),
    .evt_prev_q (evt_prev_q)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
    localparam int NE = 40;
    localparam int NC = 20;
    localparam int NH = 10;
    localparam logic [31:0] NONE = 32'h8000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_in = '0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NH-1:0] host_irq;

    always #4 clk = ~clk;

    irq_route_ctrl #(.N_EVT(NE), .N_CH(NC), .N_HOST(NH)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [NE-1:0] m_pend = '0;
    logic [NE-1:0] m_en = '0;
    logic [3:0]    m_ch [NE];
    logic [3:0]    m_hs [NC];
    logic [NH-1:0] m_hen = '0;
    logic          m_gen = 1'b0;

    function automatic logic [31:0] exp_idx(int h);
        for (int c = 0; c < NC; c++)
            for (int e = 0; e < NE; e++)
                if (m_pend[e] && m_en[e] && int'(m_ch[e]) == c && int'(m_hs[c]) == h)
                    return 32'(e);
        return NONE;
    endfunction

    function automatic logic [NH-1:0] exp_irq();
        logic [NH-1:0] r = '0;
        for (int h = 0; h < NH; h++) r[h] = m_gen && m_hen[h] && (exp_idx(h) != NONE);
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        logic [31:0] r = '0;
        int k;
        if (a == 8'h00) r[0] = m_gen;
        else if (a == 8'h03) r[NH-1:0] = m_hen;
        else if ((a >= 8'h08 && a < 8'h0A) || (a >= 8'h10 && a < 8'h12)) begin
            k = int'(a[2:0]);
            for (int b = 0; b < 32; b++) if (k*32 + b < NE) r[b] = m_en[k*32 + b];
        end else if (a >= 8'h18 && a < 8'h1A) begin
            k = int'(a) - 8'h18;
            for (int b = 0; b < 32; b++) if (k*32 + b < NE) r[b] = m_pend[k*32 + b];
        end else if (a >= 8'h40 && a < 8'h4A) begin
            k = int'(a) - 8'h40;
            for (int s = 0; s < 4; s++) r[s*8 +: 4] = m_ch[k*4 + s];
        end else if (a >= 8'h70 && a < 8'h75) begin
            k = int'(a) - 8'h70;
            for (int s = 0; s < 4; s++) r[s*8 +: 4] = m_hs[k*4 + s];
        end else if (a >= 8'h80 && a < 8'h8A) begin
            r = exp_idx(int'(a) - 8'h80);
        end
        return r;
    endfunction

    function automatic void apply_wr(logic [7:0] a, logic [31:0] d);
        int k;
        if (a == 8'h00) m_gen = d[0];
        else if (a == 8'h01) begin if (d < NH) m_hen[d] = 1'b1; end
        else if (a == 8'h02) begin if (d < NH) m_hen[d] = 1'b0; end
        else if (a >= 8'h08 && a < 8'h0A) begin
            k = int'(a) - 8'h08;
            for (int b = 0; b < 32; b++) if (k*32 + b < NE && d[b]) m_en[k*32 + b] = 1'b1;
        end else if (a >= 8'h10 && a < 8'h12) begin
            k = int'(a) - 8'h10;
            for (int b = 0; b < 32; b++) if (k*32 + b < NE && d[b]) m_en[k*32 + b] = 1'b0;
        end else if (a >= 8'h18 && a < 8'h1A) begin
            k = int'(a) - 8'h18;
            for (int b = 0; b < 32; b++) if (k*32 + b < NE && d[b]) m_pend[k*32 + b] = 1'b0;
        end else if (a >= 8'h40 && a < 8'h4A) begin
            k = int'(a) - 8'h40;
            for (int s = 0; s < 4; s++) m_ch[k*4 + s] = d[s*8 +: 4];
        end else if (a >= 8'h70 && a < 8'h75) begin
            k = int'(a) - 8'h70;
            for (int s = 0; s < 4; s++) m_hs[k*4 + s] = d[s*8 +: 4];
        end
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
        apply_wr(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_re = 1'b1; bus_addr = a;
        @(negedge clk); bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic chk_rd(input string tag, input logic [7:0] a);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp_rd(a));
    endtask

    task automatic pulse(input logic [NE-1:0] m);
        @(negedge clk); evt_in = m;
        @(negedge clk); evt_in = '0;
        m_pend = m_pend | m;
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, 32'(host_irq), 32'(exp_irq()));
    endtask

    function automatic logic [7:0] pick_addr();
        case ($urandom_range(0, 13))
            0:  return 8'h00;
            1:  return 8'h01;
            2:  return 8'h02;
            3:  return 8'h03;
            4:  return 8'h08 + 8'($urandom_range(0, 1));
            5:  return 8'h10 + 8'($urandom_range(0, 1));
            6:  return 8'h18 + 8'($urandom_range(0, 1));
            7, 8: return 8'h40 + 8'($urandom_range(0, 9));
            9:  return 8'h70 + 8'($urandom_range(0, 4));
            10, 11: return 8'h80 + 8'($urandom_range(0, 9));
            12: return 8'h04;
            default: return 8'h90;
        endcase
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        for (int e = 0; e < NE; e++) m_ch[e] = '0;
        for (int c = 0; c < NC; c++) m_hs[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 32'(host_irq), 32'h0);
        rd(8'h80, v); chk("R1 prio none", v, NONE);
        rd(8'h40, v); chk("R1 cmap", v, 32'h0);
        rd(8'h18, v); chk("R1 pend", v, 32'h0);
        rd(8'h00, v); chk("R1 glb", v, 32'h0);

        // R11 unassigned and read-only
        rd(8'h04, v); chk("R11 unassigned", v, 32'h0);
        wr(8'h03, 32'hFFFF_FFFF);
        rd(8'h03, v); chk("R11 ro hmsk", v, 32'h0);

        // R5 upper nibbles dropped
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R5 nibble", v, 32'h0F0F_0F0F);
        wr(8'h40, 32'h0);

        // R10 priority: event5->ch3, event2->ch7, both ch->host1
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h09, 32'h0000_00FF);
        rd(8'h09, v); chk("R4 partial word", v, 32'h0000_00FF);
        wr(8'h41, 32'h0000_0300);
        wr(8'h40, 32'h0007_0000);
        wr(8'h70, 32'h0100_0000);
        wr(8'h71, 32'h0100_0000);
        pulse(NE'(40'h24));
        rd(8'h81, v); chk("R10 low channel wins", v, 32'd5);
        chk("R8 glb off", 32'(host_irq), 32'h0);
        wr(8'h00, 32'h1);
        chk("R9 host disabled", 32'(host_irq), 32'h0);
        wr(8'h01, 32'd1);
        chk("R9 host1 on", 32'(host_irq), 32'h2);
        wr(8'h01, 32'd11);
        rd(8'h03, v); chk("R7 bad index", v, 32'h2);
        wr(8'h41, 32'h0000_0303);
        pulse(NE'(40'h10));
        rd(8'h81, v); chk("R10 low event in channel", v, 32'd4);

        // R3 clear
        wr(8'h18, 32'h30);
        rd(8'h81, v); chk("R3 clear", v, 32'd2);

        // R6 host field beyond host count
        wr(8'h71, 32'h0C00_0000);
        rd(8'h81, v); chk("R6 route nowhere", v, NONE);
        chk("R6 irq", 32'(host_irq), 32'h0);

        // R2 held line does not re-latch
        @(negedge clk); evt_in[3] = 1'b1;
        m_pend[3] = 1'b1;
        repeat (2) @(negedge clk);
        wr(8'h18, 32'h8);
        repeat (2) @(negedge clk);
        rd(8'h18, v); chk("R2 held no relatch", v, exp_rd(8'h18));
        @(negedge clk); evt_in[3] = 1'b0;

        // R3 edge wins over clear
        @(negedge clk); evt_in[6] = 1'b1; bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h40;
        @(negedge clk); evt_in[6] = 1'b0; bus_we = 1'b0;
        m_pend[6] = 1'b1;
        rd(8'h18, v); chk("R3 edge wins", v[6], 32'h1);

        // R4 enable clear
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R4 clear", v, 32'h0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            case ($urandom_range(0, 9))
                0, 1: pulse(NE'({$urandom, $urandom} & {$urandom, $urandom}));
                2, 3, 4: begin
                    a = pick_addr();
                    if (a == 8'h01 || a == 8'h02) wr(a, 32'($urandom_range(0, 15)));
                    else wr(a, $urandom);
                end
                default: begin
                    a = pick_addr();
                    chk_rd("R11 R10 R5 R6 R4 R3 random read", a);
                end
            endcase
            chk_irq("R9 random irq");
        end

        finish_run();
    end
endmodule